// File: doc/BRIEF.md
# Address-Encoded MDIO Management Master

This block turns single register accesses from a host into complete MDIO management frames on an MDC clock line and a shared MDIO data line. The host supplies no command word. The register address itself selects the target PHY, an operation code and a 5-bit register or device field. The write data, or the data returned by a read, carries the 16-bit payload. Clause-22 reads and writes are supported. So are clause-45 address, data and auto-incrementing data operations. A clause-45 read or write takes two host accesses: an address-phase write that loads the register number into the PHY, then a data access.

The host raises `host_req` with `host_we`, `host_addr` and `host_wdata` stable and holds them until `host_ready` pulses. The block accepts a request only while idle. It serializes successive requests in arrival order and holds `host_ready` low until the last bit of the frame has completed. MDC comes from a divider of the system clock, with `MDC_HALF` system clocks in each half period.

The sequencer moves through these states: IDLE, then PRE (32 preamble bits), then HDR (start, op, PHY and register/device fields, 14 bits), then TA (2 turnaround bits), then DATA (16 bits), then ACK (one cycle), then back to IDLE. Each transition other than IDLE to PRE and ACK to IDLE happens on the last system clock of the last bit of its phase. IDLE moves to PRE on the edge that accepts a request. ACK always returns to IDLE on the next edge.

Top module: `mdio_reg_master`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `host_ready`, `mdc` and `mdio_oe` are all low.
- R2: `host_addr[11:7]` is sent as the 5-bit PHY field, and `host_addr[4:0]` is sent as the register (clause 22) or device (clause 45) field. Both are sent MSB first after the op bits. `host_addr[6:5]` is the opcode.
- R3: Every frame begins with 32 consecutive 1 bits driven on MDIO.
- R4: Opcode 1 sends a clause-22 frame with start bits 01, and op bits 10 for a host read or 01 for a host write.
- R5: The remaining opcodes send clause-45 frames with start bits 00. Opcode 0 uses op 00 (address phase). Opcode 2 and opcode 3 use op 01 on a write. A read with opcode 2 uses op 11, and a read with opcode 3 uses op 10.
- R6: On a write frame the block drives turnaround 1 then 0, then `host_wdata` MSB first. `host_rdata` returns zero.
- R7: On a read frame MDIO is released for the turnaround and the 16 data bits. Each data bit is taken from `mdio_i` on the system edge where MDC rises, MSB first. The result is returned in `host_rdata[15:0]`, with `host_rdata[31:16]` zero.
- R8: In a frame each bit lasts 2*MDC_HALF system clocks: MDC is low for the first MDC_HALF and high for the rest. MDIO changes only at the start of the low half. MDC is low whenever the block is idle.
- R9: A request seen while idle is accepted on that edge, and `busy` is high from the next cycle. `host_ready` pulses for exactly one cycle, 64*2*MDC_HALF cycles after acceptance. A new request is not accepted in that cycle, so requests run one after another.
- R10: An opcode-0 access issues an address frame carrying `host_wdata`, whether it is a host read or a host write, and returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until `host_ready` |
| host_we | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | 12 | PHY[11:7], opcode[6:5], register/device[4:0] |
| host_wdata | input | 16 | Write payload, or register number for opcode 0 |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read payload in bits 15:0, valid with `host_ready` |
| busy | output | 1 | A frame is in progress or being acknowledged |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Acceptance happens on the edge where `host_req` is seen while idle. From the following cycle the frame runs for 64 bits of 2*MDC_HALF clocks each. `host_ready`, together with the read payload, appears one cycle after the final clock of bit 63. Read bits must be present on `mdio_i` when the system edge raises MDC. The bench model steps through the same elapsed-cycle count from its own record of acceptance and predicts `busy`, `mdc`, `mdio_oe`, `mdio_o` and `host_ready` for every cycle. It compares these on each falling system edge, away from the edge where the design updates. It also drives its simulated PHY data from that timeline, so a sample taken one cycle early or late shows up as a wrong read value.

// File: rtl/mdio_reg_pkg.sv
package mdio_reg_pkg;

    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int FLD_W     = 5;
    localparam int OPC_W     = 2;
    localparam int PHY_W     = 5;
    localparam int ADDR_W    = PHY_W + OPC_W + FLD_W;
    localparam int SHIFT_W   = HDR_BITS + TA_BITS + DATA_BITS;
    localparam int RD_W      = 32;
    localparam int CNT_W     = $clog2(PRE_BITS);

    typedef enum logic [OPC_W-1:0] {
        OPC_C45_ADDR = 2'd0,
        OPC_C22      = 2'd1,
        OPC_C45_DATA = 2'd2,
        OPC_C45_INC  = 2'd3
    } opc_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_HDR,
        S_TA,
        S_DATA,
        S_ACK
    } seq_state_e;

    typedef struct packed {
        logic               rd;
        logic [SHIFT_W-1:0] bits;
    } frame_t;

endpackage

// File: rtl/mdio_addr_decode.sv
module mdio_addr_decode
    import mdio_reg_pkg::*;
(
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_BITS-1:0] wdata,
    output frame_t               frame
);

    opc_e             opc;
    logic [PHY_W-1:0] phy;
    logic [FLD_W-1:0] fld;
    logic [1:0]       st;
    logic [1:0]       op;
    logic             rd;

    always_comb begin
        opc = opc_e'(addr[FLD_W +: OPC_W]);
        phy = addr[FLD_W+OPC_W +: PHY_W];
        fld = addr[FLD_W-1:0];
        st  = 2'b00;
        op  = 2'b00;
        unique case (opc)
            OPC_C22: begin
                st = 2'b01;
                op = we ? 2'b01 : 2'b10;
            end
            OPC_C45_ADDR: op = 2'b00;
            OPC_C45_DATA: op = we ? 2'b01 : 2'b11;
            OPC_C45_INC:  op = we ? 2'b01 : 2'b10;
            default:      op = 2'b00;
        endcase
        rd = !we && (opc != OPC_C45_ADDR);
        frame.rd   = rd;
        frame.bits = {st, op, phy, fld, 2'b10, (rd ? {DATA_BITS{1'b0}} : wdata)};
    end

endmodule

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer #(
    parameter int MDC_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic sample_stb,
    output logic bit_end
);

    localparam int PER  = 2 * MDC_HALF;
    localparam int PH_W = (PER > 1) ? $clog2(PER) : 1;

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (!run || ph == PH_W'(PER-1)) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    always_comb begin
        mdc        = run && (ph >= PH_W'(MDC_HALF));
        sample_stb = run && (ph == PH_W'(MDC_HALF-1));
        bit_end    = run && (ph == PH_W'(PER-1));
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_reg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  frame_t          frm,
    input  logic            sample_stb,
    input  logic            bit_end,
    input  logic            mdio_i,
    output logic            run,
    output logic            busy,
    output logic            ready,
    output logic [RD_W-1:0] rdata,
    output logic            mdio_o,
    output logic            mdio_oe
);

    seq_state_e           state, nxt;
    logic [CNT_W-1:0]     bcnt;
    logic [SHIFT_W-1:0]   tx;
    logic [DATA_BITS-1:0] rx;
    logic                 rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (req) nxt = S_PRE;
            S_PRE:  if (bit_end && bcnt == CNT_W'(PRE_BITS-1))  nxt = S_HDR;
            S_HDR:  if (bit_end && bcnt == CNT_W'(HDR_BITS-1))  nxt = S_TA;
            S_TA:   if (bit_end && bcnt == CNT_W'(TA_BITS-1))   nxt = S_DATA;
            S_DATA: if (bit_end && bcnt == CNT_W'(DATA_BITS-1)) nxt = S_ACK;
            S_ACK:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // datapath: bit counter, shifters, result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt  <= '0;
            tx    <= '0;
            rx    <= '0;
            rd    <= 1'b0;
            rdata <= '0;
        end else begin
            if (state == S_IDLE && req) begin
                tx   <= frm.bits;
                rd   <= frm.rd;
                bcnt <= '0;
                rx   <= '0;
            end
            if (bit_end) begin
                bcnt <= (nxt != state) ? '0 : bcnt + 1'b1;
                if (state == S_HDR || state == S_TA || state == S_DATA)
                    tx <= {tx[SHIFT_W-2:0], 1'b0};
            end
            if (sample_stb && state == S_DATA && rd)
                rx <= {rx[DATA_BITS-2:0], mdio_i};
            if (state == S_DATA && nxt == S_ACK)
                rdata <= rd ? {{(RD_W-DATA_BITS){1'b0}}, rx} : '0;
        end
    end

    // outputs
    always_comb begin
        run     = (state == S_PRE) || (state == S_HDR) ||
                  (state == S_TA)  || (state == S_DATA);
        busy    = (state != S_IDLE);
        ready   = (state == S_ACK);
        mdio_oe = (state == S_PRE) || (state == S_HDR) ||
                  (((state == S_TA) || (state == S_DATA)) && !rd);
        mdio_o  = (state == S_PRE) ? 1'b1 : (mdio_oe && tx[SHIFT_W-1]);
    end

endmodule

// File: rtl/mdio_reg_master.sv
module mdio_reg_master
    import mdio_reg_pkg::*;
#(
    parameter int MDC_HALF = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [DATA_BITS-1:0] host_wdata,
    output logic                 host_ready,
    output logic [RD_W-1:0]      host_rdata,
    output logic                 busy,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i
);

    frame_t frm;
    logic   run;
    logic   sample_stb;
    logic   bit_end;

    mdio_addr_decode u_dec (
        .we    (host_we),
        .addr  (host_addr),
        .wdata (host_wdata),
        .frame (frm)
    );

    mdio_mdc_timer #(.MDC_HALF(MDC_HALF)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .mdc        (mdc),
        .sample_stb (sample_stb),
        .bit_end    (bit_end)
    );

    mdio_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (host_req),
        .frm        (frm),
        .sample_stb (sample_stb),
        .bit_end    (bit_end),
        .mdio_i     (mdio_i),
        .run        (run),
        .busy       (busy),
        .ready      (host_ready),
        .rdata      (host_rdata),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

endmodule

// File: rtl/mdio_reg_master_chk.sv
module mdio_reg_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_req,
    input logic        host_ready,
    input logic [15:0] rdata_hi,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!busy && !host_ready && !mdc && !mdio_oe));

    a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_req) |=> busy);

    a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    a_r9_ready_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> busy);

    a_r8_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r6_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (busy && !host_ready));

    a_r3_frame_starts_ones: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe && mdio_o));

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (rdata_hi == 16'h0000));

endmodule

bind mdio_reg_master mdio_reg_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_ready (host_ready),
    .rdata_hi   (host_rdata[31:16]),
    .busy       (busy),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
);

// File: tb/tb_mdio_reg_master.sv
`timescale 1ns/1ps
module tb_mdio_reg_master;

    localparam int HALF   = 2;
    localparam int PER    = 2 * HALF;
    localparam int NBITS  = 64;
    localparam int LAST_T = NBITS * PER - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        busy;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mdio_reg_master #(.MDC_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // reference model state
    bit          m_active = 0;
    bit          m_ack = 0;
    int          m_t = 0;
    bit          m_rd = 0;
    bit          m_c22 = 0;
    bit          m_op0 = 0;
    logic [15:0] m_pat = '0;
    logic [31:0] m_rdata = '0;
    logic [15:0] phy_pat = '0;
    bit          ex_bit [NBITS];
    bit          ex_oe  [NBITS];
    logic [1:0]  mo_st, mo_op, mo_opc;
    logic [13:0] mo_hdr;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_ack = 0; m_t = 0;
        end else if (m_active) begin
            if (m_t == LAST_T) begin m_active = 0; m_ack = 1; end
            else m_t = m_t + 1;
        end else if (m_ack) begin
            m_ack = 0;
        end else if (host_req) begin
            mo_opc = host_addr[6:5];
            m_c22  = (mo_opc == 2'd1);
            m_op0  = (mo_opc == 2'd0);
            m_rd   = !host_we && !m_op0;
            mo_st  = m_c22 ? 2'b01 : 2'b00;
            if (m_c22)          mo_op = host_we ? 2'b01 : 2'b10;
            else if (m_op0)     mo_op = 2'b00;
            else if (host_we)   mo_op = 2'b01;
            else if (mo_opc == 2'd2) mo_op = 2'b11;
            else                mo_op = 2'b10;
            mo_hdr = {mo_st, mo_op, host_addr[11:7], host_addr[4:0]};
            for (int i = 0; i < 32; i++) begin ex_bit[i] = 1; ex_oe[i] = 1; end
            for (int i = 0; i < 14; i++) begin ex_bit[32+i] = mo_hdr[13-i]; ex_oe[32+i] = 1; end
            ex_bit[46] = 1; ex_bit[47] = 0; ex_oe[46] = !m_rd; ex_oe[47] = !m_rd;
            for (int i = 0; i < 16; i++) begin
                ex_bit[48+i] = host_wdata[15-i];
                ex_oe[48+i]  = !m_rd;
            end
            m_pat   = phy_pat;
            m_rdata = m_rd ? {16'h0000, phy_pat} : 32'h0;
            m_active = 1; m_t = 0;
        end
    end

    function automatic string pos_tag(input int b);
        if (b < 32) return "R3";
        if (b < 36) return m_c22 ? "R4" : "R5";
        if (b < 46) return "R2";
        if (m_rd) return "R7";
        return m_op0 ? "R10" : "R6";
    endfunction

    // compare every cycle away from the active edge; drive simulated PHY
    always @(negedge clk) begin
        int  b;
        bit  e_oe;
        b    = m_active ? (m_t / PER) : 0;
        e_oe = m_active && ex_oe[b];
        mdio_i = (m_active && m_rd && b >= 48) ? m_pat[63-b] : 1'b1;
        if (!done) begin
            check(rst_n ? "R9 busy" : "R1 busy", {31'h0, busy}, {31'h0, m_active || m_ack});
            check(rst_n ? "R9 ready" : "R1 ready", {31'h0, host_ready}, {31'h0, m_ack});
            check(rst_n ? "R8 mdc" : "R1 mdc", {31'h0, mdc},
                  {31'h0, m_active && ((m_t % PER) >= HALF)});
            check(m_active ? {pos_tag(b), " oe"} : (rst_n ? "R9 oe" : "R1 oe"),
                  {31'h0, mdio_oe}, {31'h0, e_oe});
            if (e_oe)
                check({pos_tag(b), " mdio"}, {31'h0, mdio_o}, {31'h0, ex_bit[b]});
            if (m_ack)
                check(m_rd ? "R7 rdata" : (m_op0 ? "R10 rdata" : "R6 rdata"),
                      host_rdata, m_rdata);
        end
    end

    task automatic xfer(input bit we, input logic [1:0] opc, input logic [4:0] phy,
                        input logic [4:0] fld, input logic [15:0] wd, input logic [15:0] pat);
        phy_pat    = pat;
        host_we    = we;
        host_addr  = {phy, opc, fld};
        host_wdata = wd;
        host_req   = 1'b1;
        do @(negedge clk); while (host_ready !== 1'b1);
        host_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", {31'h0, busy}, 32'h0);
        check("R1 ready", {31'h0, host_ready}, 32'h0);
        check("R1 mdc", {31'h0, mdc}, 32'h0);
        check("R1 oe", {31'h0, mdio_oe}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", {31'h0, busy}, 32'h0);
        xfer(1, 2'd1, 5'd3,  5'h1F, 16'hA5C3, 16'h0000);   // R4 write
        xfer(0, 2'd1, 5'h1F, 5'd1,  16'h0000, 16'h8001);   // R4 read, R7
        repeat (5) @(negedge clk);
        check("R9 idle gap", {31'h0, busy}, 32'h0);
        xfer(1, 2'd0, 5'd5,  5'h1E, 16'h1234, 16'h0000);   // R5 address phase
        xfer(0, 2'd2, 5'd5,  5'h1E, 16'h0000, 16'hBEEF);   // R5 read op 11, R7
        xfer(1, 2'd2, 5'd10, 5'd7,  16'h0F0F, 16'h0000);   // R5 write, R6
        xfer(1, 2'd3, 5'd21, 5'd2,  16'hFFFF, 16'h0000);   // R5 inc write
        xfer(0, 2'd3, 5'd21, 5'd2,  16'h0000, 16'h5A5A);   // R5 inc read op 10
        xfer(0, 2'd0, 5'd0,  5'd0,  16'h00FF, 16'hFFFF);   // R10 opcode-0 read
        xfer(1, 2'd1, 5'd0,  5'd0,  16'h0001, 16'h0000);   // R2 zero fields
        xfer(0, 2'd1, 5'd9,  5'd22, 16'h0000, 16'h7FFE);   // R7
        repeat (8) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule